// File: doc/BRIEF.md
# Solenoid Driver Power-Up Sequencer

This block takes an eight-channel solenoid and motor driver from power-off to a usable state. On a start pulse it raises the driver's enable pin and waits out the enable settling time. It then issues a fixed series of register accesses through the request port of an SPI register access engine. The first access is a status read, which clears the undervoltage flag that the driver latches at power-up. Next the global status word is written with the active bit, the channel-pair mode bits and the fault masks. Then one configuration word is written for each channel, taken from a parameter table. Last, once the wake-up time since the active bit was written has passed, the status word is read again.

The final status read decides the outcome. If it is clean, `ready` is raised. If it shows the undervoltage flag or any masked fault, `init_err` is raised and held. `init_err` is also raised as soon as any access returns the communication-error code in its command-phase flag byte. A disable request from any active state drops the enable pin at once and raises `busy_disabling` for the output tristate delay, after which the block is idle again. `restart` leaves the error state through the same disable path.

All waits are counted in clock cycles derived from `CLK_HZ` and the microsecond parameters `T_EN_US` (500), `T_WAKE_US` (2500) and `T_DIS_US` (2500). In what follows, EN, WAKE and DIS are those times in cycles: `CLK_HZ/1000 * T_US / 1000`, never less than 1.

Top module: `drv_init_seq`

## Requirements
- R1: While and after reset, with no start pulse, `drv_en`, `req_valid`, `ready`, `init_err` and `busy_disabling` are all low.
- R2: A start pulse in the idle state raises `drv_en` after the next clock edge. `req_valid` is first asserted exactly EN cycles after `drv_en` rises.
- R3: The accesses come in this order, each held stable until accepted by `req_ready`: a read of address 0; a write of `STATUS_INIT` to address 0; for channels n = 0 to NUM_CH-1 in ascending order, a write of table word n (bits 32n+31..32n of `CH_CFG`) to address n+1; a final read of address 0. That is NUM_CH+3 accesses in all.
- R4: The data returned by the first status read has no effect. The sequence continues even when that data has the undervoltage bit or fault bits set.
- R5: The final status read request is first asserted WAKE cycles after the clock edge that accepts the status-write response, provided the configuration writes finish sooner.
- R6: If the final read data has bit `UV_BIT` set, or any bit of `FAULT_MASK` set, `init_err` rises. Otherwise `ready` rises. Bits outside both are ignored.
- R7: A response whose flag byte equals 8'h04 raises `init_err` and stops further requests, whichever access it belongs to. Any other flag value has no effect.
- R8: `init_err` holds until `restart` (or `disable_req`) is asserted. `restart` in the error state enters the disable wait.
- R9: `disable_req` in any state other than idle and disabling drops `drv_en` after the next edge and holds `busy_disabling` high for exactly DIS cycles, with no request issued. The block then returns to idle. Responses that arrive in this window are ignored.
- R10: At most one of `ready`, `init_err` and `busy_disabling` is high at a time, and `req_valid` is high only while `drv_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins power-up from idle |
| disable_req | input | 1 | Drops enable and starts the tristate wait |
| restart | input | 1 | Leaves the error state through the disable wait |
| drv_en | output | 1 | Driver enable pin |
| req_valid | output | 1 | Access request to the SPI engine |
| req_ready | input | 1 | Engine accepts the request this cycle |
| req_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | 4 | Register address (0 = status, n+1 = channel n) |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Access completed this cycle |
| rsp_flags | input | 8 | Flag byte returned during the command phase |
| rsp_rdata | input | 32 | Read data |
| ready | output | 1 | Initialization finished without faults |
| init_err | output | 1 | Initialization failed; held until restart |
| busy_disabling | output | 1 | Enable is low and outputs are still settling |

## Verification
A wrong step counter shows on `req_addr` and `req_wdata` of the next accepted request, within one access: a skipped, repeated or misordered channel shows up there. A state register that leaves the enable or wake wait early shows in the cycle of the first or final `req_valid`, which is compared to the exact cycle count. A wrong decision on the final read or on the flag byte shows as the wrong one of `ready` and `init_err` one cycle after the response. A wrong disable timer shows as a `busy_disabling` pulse of the wrong length.

// File: rtl/drv_init_pkg.sv
package drv_init_pkg;

    localparam int          ADDR_W      = 4;
    localparam int          DATA_W      = 32;
    localparam logic [7:0]  COMER_CODE  = 8'h04;
    localparam logic [ADDR_W-1:0] STATUS_ADDR = '0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EN_WAIT,
        ST_REQ,
        ST_RSP,
        ST_WAKE,
        ST_READY,
        ST_FAIL,
        ST_DISABLING
    } seq_state_e;

    // Microseconds to clock cycles, never less than one.
    function automatic int unsigned us_to_cyc(input longint unsigned clk_hz,
                                              input longint unsigned us);
        longint unsigned c;
        c = (clk_hz / 64'd1000) * us / 64'd1000;
        if (c == 0) c = 1;
        return c[31:0];
    endfunction

    function automatic logic status_bad(input logic [DATA_W-1:0] d,
                                        input logic [DATA_W-1:0] bad_mask);
        return |(d & bad_mask);
    endfunction

endpackage

// File: rtl/drv_init_timer.sv
module drv_init_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/drv_init_cfg_sel.sv
module drv_init_cfg_sel
    import drv_init_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int IDX_W  = 4,
    parameter logic [NUM_CH*DATA_W-1:0] TABLE = '0
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] words [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_unpack
        assign words[g] = TABLE[g*DATA_W +: DATA_W];
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (idx == IDX_W'(i)) word = words[i];
        end
    end
endmodule

// File: rtl/drv_init_fsm.sv
module drv_init_fsm
    import drv_init_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int STEP_W = 4,
    parameter int TW     = 8,
    parameter int unsigned EN_CYC  = 1,
    parameter int unsigned DIS_CYC = 1,
    parameter logic [DATA_W-1:0] BAD_MASK = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              disable_req,
    input  logic              restart,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [7:0]        rsp_flags,
    input  logic [DATA_W-1:0] rsp_rdata,
    input  logic              ph_done,
    input  logic              wake_done,
    output seq_state_e        st,
    output logic [STEP_W-1:0] step,
    output logic              ph_load,
    output logic [TW-1:0]     ph_val,
    output logic              wake_load
);
    localparam logic [STEP_W-1:0] STEP_STAT    = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_LASTCFG = STEP_W'(NUM_CH + 1);
    localparam logic [STEP_W-1:0] STEP_FINAL   = STEP_W'(NUM_CH + 2);

    seq_state_e        st_n;
    logic [STEP_W-1:0] step_n;
    logic              active;

    assign active = (st != ST_IDLE) && (st != ST_DISABLING);

    always_comb begin
        st_n      = st;
        step_n    = step;
        ph_load   = 1'b0;
        ph_val    = '0;
        wake_load = 1'b0;
        if ((disable_req && active) || (st == ST_FAIL && restart)) begin
            st_n    = ST_DISABLING;
            ph_load = 1'b1;
            ph_val  = TW'(DIS_CYC - 1);
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st_n    = ST_EN_WAIT;
                    step_n  = '0;
                    ph_load = 1'b1;
                    ph_val  = TW'(EN_CYC - 1);
                end
                ST_EN_WAIT: if (ph_done) st_n = ST_REQ;
                ST_REQ:     if (req_ready) st_n = ST_RSP;
                ST_RSP: if (rsp_valid) begin
                    if (rsp_flags == COMER_CODE) begin
                        st_n = ST_FAIL;
                    end else if (step == STEP_FINAL) begin
                        st_n = status_bad(rsp_rdata, BAD_MASK) ? ST_FAIL : ST_READY;
                    end else begin
                        if (step == STEP_STAT) wake_load = 1'b1;
                        if (step == STEP_LASTCFG) begin
                            st_n = ST_WAKE;
                        end else begin
                            step_n = step + 1'b1;
                            st_n   = ST_REQ;
                        end
                    end
                end
                ST_WAKE: if (wake_done) begin
                    step_n = STEP_FINAL;
                    st_n   = ST_REQ;
                end
                ST_DISABLING: if (ph_done) st_n = ST_IDLE;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            step <= '0;
        end else begin
            st   <= st_n;
            step <= step_n;
        end
    end
endmodule

// File: rtl/drv_init_seq.sv
module drv_init_seq
    import drv_init_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 125_000_000,
    parameter int unsigned T_EN_US   = 500,
    parameter int unsigned T_WAKE_US = 2500,
    parameter int unsigned T_DIS_US  = 2500,
    parameter int          NUM_CH    = 8,
    parameter int          UV_BIT    = 0,
    parameter logic [31:0] FAULT_MASK  = 32'h0000_00FE,
    parameter logic [31:0] STATUS_INIT = 32'h0000_0001,
    parameter logic [NUM_CH*32-1:0] CH_CFG = {NUM_CH{32'h4020_0000}}
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        disable_req,
    input  logic        restart,
    output logic        drv_en,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_write,
    output logic [3:0]  req_addr,
    output logic [31:0] req_wdata,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_flags,
    input  logic [31:0] rsp_rdata,
    output logic        ready,
    output logic        init_err,
    output logic        busy_disabling
);
    localparam int unsigned EN_CYC   = us_to_cyc(CLK_HZ, T_EN_US);
    localparam int unsigned WAKE_CYC = us_to_cyc(CLK_HZ, T_WAKE_US);
    localparam int unsigned DIS_CYC  = us_to_cyc(CLK_HZ, T_DIS_US);
    localparam int unsigned MAX_A    = (EN_CYC > DIS_CYC) ? EN_CYC : DIS_CYC;
    localparam int unsigned MAX_CYC  = (MAX_A > WAKE_CYC) ? MAX_A : WAKE_CYC;
    localparam int TW     = $clog2(MAX_CYC + 1);
    localparam int STEP_W = $clog2(NUM_CH + 3);
    localparam logic [31:0] BAD_MASK = FAULT_MASK | (32'd1 << UV_BIT);

    seq_state_e        st;
    logic [STEP_W-1:0] step;
    logic              ph_load, wake_load, ph_done, wake_done;
    logic [TW-1:0]     ph_val;
    logic [31:0]       cfg_word;

    drv_init_fsm #(
        .NUM_CH(NUM_CH), .STEP_W(STEP_W), .TW(TW),
        .EN_CYC(EN_CYC), .DIS_CYC(DIS_CYC), .BAD_MASK(BAD_MASK)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .disable_req(disable_req),
        .restart(restart), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_flags(rsp_flags), .rsp_rdata(rsp_rdata), .ph_done(ph_done),
        .wake_done(wake_done), .st(st), .step(step), .ph_load(ph_load),
        .ph_val(ph_val), .wake_load(wake_load)
    );

    drv_init_timer #(.W(TW)) u_ph_tmr (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .done(ph_done)
    );

    drv_init_timer #(.W(TW)) u_wake_tmr (
        .clk(clk), .rst(rst), .load(wake_load),
        .load_val(TW'(WAKE_CYC - 1)), .done(wake_done)
    );

    drv_init_cfg_sel #(.NUM_CH(NUM_CH), .IDX_W(STEP_W), .TABLE(CH_CFG)) u_cfg (
        .idx(step - STEP_W'(2)), .word(cfg_word)
    );

    always_comb begin
        req_write = 1'b0;
        req_addr  = STATUS_ADDR;
        req_wdata = '0;
        if (step == STEP_W'(1)) begin
            req_write = 1'b1;
            req_wdata = STATUS_INIT;
        end else if (step >= STEP_W'(2) && step <= STEP_W'(NUM_CH + 1)) begin
            req_write = 1'b1;
            req_addr  = ADDR_W'(step - STEP_W'(1));
            req_wdata = cfg_word;
        end
    end

    assign req_valid      = (st == ST_REQ);
    assign drv_en         = (st != ST_IDLE) && (st != ST_DISABLING);
    assign ready          = (st == ST_READY);
    assign init_err       = (st == ST_FAIL);
    assign busy_disabling = (st == ST_DISABLING);
endmodule

// File: rtl/drv_init_seq_chk.sv
module drv_init_seq_chk
    import drv_init_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 125_000_000,
    parameter int unsigned T_EN_US = 500
) (
    input logic        clk,
    input logic        rst,
    input logic        disable_req,
    input logic        restart,
    input logic        drv_en,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [3:0]  req_addr,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic        ready,
    input logic        init_err,
    input logic        busy_disabling
);
    localparam int unsigned EN_CYC = us_to_cyc(CLK_HZ, T_EN_US);

    logic [31:0] en_cnt;
    always_ff @(posedge clk) begin
        if (rst || !drv_en)      en_cnt <= '0;
        else if (en_cnt != '1)   en_cnt <= en_cnt + 1'b1;
    end

    // R2
    en_wait_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> en_cnt >= EN_CYC);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready && !disable_req |=>
            req_valid && $stable(req_addr) && $stable(req_wdata) && $stable(req_write));

    // R6
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(rsp_valid));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        init_err && !restart && !disable_req |=> init_err);

    // R8
    restart_path_chk: assert property (@(posedge clk) disable iff (rst)
        init_err && restart |=> busy_disabling);

    // R9
    disable_enter_chk: assert property (@(posedge clk) disable iff (rst)
        disable_req && drv_en |=> busy_disabling && !drv_en);

    // R9
    disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy_disabling |-> !drv_en && !req_valid);

    // R10
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ready, init_err, busy_disabling}));

    // R10
    req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> drv_en);
endmodule

bind drv_init_seq drv_init_seq_chk #(.CLK_HZ(CLK_HZ), .T_EN_US(T_EN_US)) u_chk (
    .clk(clk), .rst(rst), .disable_req(disable_req), .restart(restart),
    .drv_en(drv_en), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .ready(ready), .init_err(init_err),
    .busy_disabling(busy_disabling)
);

// File: tb/drv_init_seq_bench.sv
module drv_init_seq_bench;
    // The clock runs at 125 MHz; CLK_HZ is scaled down to 1 MHz so the
    // millisecond waits stay short in cycles.
    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int NCH      = 8;
    localparam int EN_CYC   = 500;
    localparam int WAKE_CYC = 2500;
    localparam int DIS_CYC  = 2500;
    localparam int UVB      = 2;
    localparam logic [31:0] FMASK = 32'h0000_0F00;
    localparam logic [31:0] SINIT = 32'h8300_00F1;
    localparam int NACC     = NCH + 3;

    function automatic logic [31:0] cfg_of(input int i);
        return 32'h5A00_0000 | (32'(i) << 16) | 32'(i * 17 + 3);
    endfunction

    function automatic logic [NCH*32-1:0] mk_cfg();
        logic [NCH*32-1:0] t;
        for (int i = 0; i < NCH; i++) t[i*32 +: 32] = cfg_of(i);
        return t;
    endfunction

    typedef struct packed {
        int          comer_at;
        logic [7:0]  comer_val;
        logic [31:0] uv_word;
        logic [31:0] fin_word;
        logic        exp_ready;
        int          exp_reqs;
    } scen_t;

    localparam int NSCEN = 8;
    localparam scen_t SCEN [NSCEN] = '{
        '{-1, 8'h00, 32'h0000_0F04, 32'h0000_0000, 1'b1, 11},
        '{ 0, 8'h04, 32'h0000_0000, 32'h0000_0000, 1'b0,  1},
        '{ 5, 8'h04, 32'h0000_0000, 32'h0000_0000, 1'b0,  6},
        '{10, 8'h04, 32'h0000_0000, 32'h0000_0000, 1'b0, 11},
        '{ 3, 8'h06, 32'h0000_0000, 32'h0000_0000, 1'b1, 11},
        '{-1, 8'h00, 32'h0000_0000, 32'h0000_0004, 1'b0, 11},
        '{-1, 8'h00, 32'h0000_0000, 32'h0000_0200, 1'b0, 11},
        '{-1, 8'h00, 32'h0000_0000, 32'hF000_10F3, 1'b1, 11}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, disable_req = 1'b0, restart = 1'b0;
    logic        drv_en, req_valid, req_write, ready, init_err, busy_disabling;
    logic        req_ready = 1'b0;
    logic [3:0]  req_addr;
    logic [31:0] req_wdata;
    logic        rsp_valid = 1'b0;
    logic [7:0]  rsp_flags = 8'h00;
    logic [31:0] rsp_rdata = 32'h0;

    int n_chk = 0, n_fail = 0, cyc = 0, n_req = 0, run_base = 0;
    int          cur_comer_at = -1;
    logic [7:0]  cur_comer_val = 8'h00;
    logic [31:0] cur_uv = 32'h0, cur_fin = 32'h0;

    logic [3:0]  log_addr [64];
    logic        log_wr   [64];
    logic [31:0] log_data [64];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    drv_init_seq #(
        .CLK_HZ(CLK_HZ), .NUM_CH(NCH), .UV_BIT(UVB), .FAULT_MASK(FMASK),
        .STATUS_INIT(SINIT), .CH_CFG(mk_cfg())
    ) u_drv_init_seq (
        .clk(clk), .rst(rst), .start(start), .disable_req(disable_req),
        .restart(restart), .drv_en(drv_en), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_flags(rsp_flags),
        .rsp_rdata(rsp_rdata), .ready(ready), .init_err(init_err),
        .busy_disabling(busy_disabling)
    );

    // Model of the SPI access engine: stalls one cycle in three, answers
    // three cycles after acceptance.
    bit          pend = 1'b0;
    int          lat = 0;
    logic [7:0]  p_flags = 8'h00;
    logic [31:0] p_data = 32'h0;
    always @(negedge clk) begin
        if (rst) begin
            pend = 1'b0; rsp_valid = 1'b0; req_ready = 1'b0;
        end else begin
            rsp_valid = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    rsp_valid = 1'b1; rsp_flags = p_flags; rsp_rdata = p_data; pend = 1'b0;
                end else lat = lat - 1;
            end
            req_ready = (cyc % 3) != 1;
            if (req_valid && req_ready) begin
                automatic int k = n_req - run_base;
                log_addr[n_req % 64] = req_addr;
                log_wr[n_req % 64]   = req_write;
                log_data[n_req % 64] = req_wdata;
                p_flags = (k == cur_comer_at) ? cur_comer_val : 8'h00;
                p_data  = req_write ? 32'h0 : ((k == 0) ? cur_uv : cur_fin);
                pend = 1'b1; lat = 2;
                n_req = n_req + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    // Counts busy_disabling cycles after a pulse on the chosen input.
    task automatic end_run(input bit use_restart, input string tag);
        int bcnt = 0;
        bit bad = 1'b0;
        tick();
        if (use_restart) restart = 1'b1; else disable_req = 1'b1;
        tick();
        restart = 1'b0; disable_req = 1'b0;
        for (int w = 0; w < DIS_CYC + 20; w++) begin
            if (busy_disabling) begin
                bcnt++;
                if (drv_en || req_valid) bad = 1'b1;
            end else if (bcnt > 0) break;
            tick();
        end
        chk(bcnt == DIS_CYC, {tag, " R9 busy_disabling length"}, bcnt, DIS_CYC);
        chk(!bad, {tag, " R9 enable low, no request while disabling"}, bad, 0);
        chk(!drv_en && !ready && !init_err && !busy_disabling,
            {tag, " R9 idle after tristate wait"},
            {drv_en, ready, init_err, busy_disabling}, 0);
    endtask

    task automatic run_scen(input scen_t s, input int id);
        int t_en = -1, t_req0 = -1, t_stat = -1, t_fin = -1, rcnt = 0;
        int base;
        string tg;
        tg = $sformatf("scen%0d", id);
        cur_comer_at = s.comer_at; cur_comer_val = s.comer_val;
        cur_uv = s.uv_word; cur_fin = s.fin_word;
        tick();
        base = n_req; run_base = n_req;
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int w = 0; w < 8000; w++) begin
            if (drv_en && t_en < 0) t_en = cyc;
            if (req_valid && t_req0 < 0) t_req0 = cyc;
            if (rsp_valid) begin
                rcnt++;
                if (rcnt == 2) t_stat = cyc;
            end
            if (req_valid && rcnt == NACC - 1 && t_fin < 0) t_fin = cyc;
            if (ready || init_err) break;
            tick();
        end
        if (id == 0) begin
            // R2: first request EN cycles after enable rises
            chk(t_req0 - t_en == EN_CYC, "R2 enable-to-first-request cycles", t_req0 - t_en, EN_CYC);
            // R5: final read WAKE cycles after the accepting edge (+1 sample offset)
            chk(t_fin - t_stat == WAKE_CYC + 1, "R5 wake wait before final read",
                t_fin - t_stat, WAKE_CYC + 1);
            for (int k = 0; k < NACC; k++) begin
                automatic logic        ewr = (k != 0) && (k != NACC - 1);
                automatic logic [3:0]  ead = (k >= 2 && k <= NCH + 1) ? 4'(k - 1) : 4'd0;
                automatic logic [31:0] edt = (k == 1) ? SINIT :
                                             ((k >= 2 && k <= NCH + 1) ? cfg_of(k - 2) : 32'h0);
                automatic int ix = (base + k) % 64;
                automatic logic [31:0] adt = log_wr[ix] ? log_data[ix] : 32'h0;
                chk(log_wr[ix] == ewr && log_addr[ix] == ead && adt == edt,
                    $sformatf("R3 access %0d (wr,addr,data)", k),
                    {log_wr[ix], log_addr[ix], adt}, {ewr, ead, edt});
            end
            // R4: first read returned UV and fault bits, yet the sequence finished
            chk(ready, "R4 first-read data ignored", ready, 1);
        end
        chk(ready == s.exp_ready && init_err == !s.exp_ready,
            {tg, " R6 R7 outcome (ready,init_err)"}, {ready, init_err}, {s.exp_ready, !s.exp_ready});
        repeat (40) tick();
        chk(n_req - base == s.exp_reqs, {tg, " R7 request count"}, n_req - base, s.exp_reqs);
        chk(ready == s.exp_ready && init_err == !s.exp_ready,
            {tg, " R8 outcome holds"}, {ready, init_err}, {s.exp_ready, !s.exp_ready});
        end_run(!s.exp_ready, tg);
    endtask

    task automatic mid_disable();
        int rcnt = 0;
        cur_comer_at = -1; cur_comer_val = 8'h00; cur_uv = 32'h0; cur_fin = 32'h0;
        tick();
        run_base = n_req;
        start = 1'b1;
        tick();
        start = 1'b0;
        for (int w = 0; w < 2000; w++) begin
            if (rsp_valid) rcnt++;
            if (rcnt >= 4 && req_valid) break;
            tick();
        end
        chk(rcnt == 4 && drv_en, "R9 reached mid-sequence before disable", rcnt, 4);
        end_run(1'b0, "mid");
        chk(!ready && !init_err, "R9 late response ignored", {ready, init_err}, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(!drv_en && !req_valid && !ready && !init_err && !busy_disabling,
            "R1 outputs low in reset", {drv_en, req_valid, ready, init_err, busy_disabling}, 0);
        rst = 1'b0;
        repeat (5) tick();
        chk(!drv_en && !req_valid && !ready && !init_err && !busy_disabling,
            "R1 idle after reset", {drv_en, req_valid, ready, init_err, busy_disabling}, 0);
        for (int i = 0; i < NSCEN; i++) run_scen(SCEN[i], i);
        mid_disable();
        // R8: restart in error leads through the disable wait; error persists before it
        run_scen(SCEN[1], 100);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule